// File: doc/BRIEF.md
# Marker Frequency Range Validator

This block takes a five-digit BCD frequency setting from panel thumbwheels. The digits are hundreds, tens and units of MHz, then tenths and hundredths of MHz. It decides whether the setting falls inside one of three permitted bands: 60 to 99.99 MHz, 240 to 279.99 MHz, or 290 to 329.99 MHz.

For a permitted setting it produces the digit word for a synthesizer that spans 20 to 160 MHz. In the lowest band the entered value is passed on as it is. In the two upper bands the value is first reduced by 180 MHz, and a separate mixer later restores that offset. The block also drives one of two path-select outputs, but only while the marker is switched on. A setting outside the bands lights a flashing fault lamp and holds both paths off. While the marker is active, its own lamp flashes. Both lamps are gated by a square wave with a 50% duty cycle, generated from the system clock by a parameterised divider.

Control is a small state machine with five states:
- `ST_IDLE`: the reset state.
- `ST_PARKED`: the setting is valid but the marker is off.
- `ST_DIRECT`: the marker is on with a low-band setting.
- `ST_MIXED`: the marker is on with an upper-band setting.
- `ST_FAULT`: the setting is invalid.

Every clock edge re-evaluates the inputs, and the state machine can move from any state to any of the four working states:
- `to_fault` when the setting is invalid. This transition takes priority over the other three.
- `to_parked` when the setting is valid and the marker is off.
- `to_direct` when the setting is valid, in the low band, with the marker on.
- `to_mixed` when the setting is valid, in an upper band, with the marker on.

Reset is the only way back to `ST_IDLE`.

Top module: `mfv_marker_validator`

## Requirements
- R1: A setting is valid only if every one of the five digits is 0 to 9 and the hundreds-and-tens value (hundreds*10 + tens) is 6 to 9, 24 to 27, or 29 to 32. Any other setting is invalid.
- R2: For a valid value of 6 to 9, `syn_hund` is 0 and `syn_tens` equals the entered tens digit. `path_direct` is 1 when `marker_en` is 1.
- R3: For a valid value of 24 to 27 or 29 to 32, the synthesizer digits carry (value - 18) as BCD. So 24..27 give hundreds 0 with tens 6..9, and 29..32 give hundreds 1 with tens 1..4.
- R4: For a valid upper-band setting with `marker_en` equal to 1, `path_mixed` is 1 and `path_direct` is 0.
- R5: For an invalid setting, `syn_hund` and `syn_tens` are 0, and `path_direct` and `path_mixed` are both 0.
- R6: `syn_units`, `syn_tenth` and `syn_hundredth` copy the entered units, tenths and hundredths digits for every setting, whether valid or not.
- R7: When `marker_en` is 0, both path outputs are 0. The synthesizer digits still follow R2 and R3.
- R8: While reset is active, all outputs are 0. After reset, every output reflects inputs that were present before the single preceding rising clock edge.
- R9: While the setting is invalid, `fault_lamp` is high for exactly HALF_CYCLES clocks out of every 2*HALF_CYCLES. For a valid setting it stays low.
- R10: While a path output is 1, `marker_lamp` is high for exactly HALF_CYCLES clocks out of every 2*HALF_CYCLES. At all other times it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tw_hund | input | 4 | Hundreds-of-MHz digit |
| tw_tens | input | 4 | Tens-of-MHz digit |
| tw_units | input | 4 | Units-of-MHz digit |
| tw_tenth | input | 4 | Tenths-of-MHz digit |
| tw_hundredth | input | 4 | Hundredths-of-MHz digit |
| marker_en | input | 1 | Marker on switch |
| syn_hund | output | 4 | Synthesizer hundreds digit |
| syn_tens | output | 4 | Synthesizer tens digit |
| syn_units | output | 4 | Synthesizer units digit |
| syn_tenth | output | 4 | Synthesizer tenths digit |
| syn_hundredth | output | 4 | Synthesizer hundredths digit |
| path_direct | output | 1 | Select direct synthesizer output |
| path_mixed | output | 1 | Select output up-mixed by 180 MHz |
| fault_lamp | output | 1 | Flashing invalid-setting indicator |
| marker_lamp | output | 1 | Flashing marker-on indicator |

## Verification
The state register drives both path outputs and both lamps directly. A wrong or stuck state therefore shows at the ports one clock after the inputs change: a path would be asserted with the marker off, or a path and the fault lamp would both be active for the same setting. A divider count that is off by one changes the number of lit clocks in every lamp window, so it becomes visible within one 2*HALF_CYCLES period. A wrong remap or a wrong band edge shows up as incorrect synthesizer digits on the first sample taken after the edge.

// File: rtl/mfv_pkg.sv
package mfv_pkg;

    localparam int DIGIT_W    = 4;
    localparam int NUM_DIGITS = 5;
    localparam int COARSE_W   = 8;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_PARKED = 3'd1,
        ST_DIRECT = 3'd2,
        ST_MIXED  = 3'd3,
        ST_FAULT  = 3'd4
    } mfv_state_e;

    typedef struct packed {
        logic [DIGIT_W-1:0] hund;
        logic [DIGIT_W-1:0] tens;
        logic [DIGIT_W-1:0] units;
        logic [DIGIT_W-1:0] tenth;
        logic [DIGIT_W-1:0] hundredth;
    } bcd5_t;

    typedef struct packed {
        logic               ok;
        logic               mixed;
        logic [DIGIT_W-1:0] hund;
        logic [DIGIT_W-1:0] tens;
    } remap_t;

endpackage

// File: rtl/mfv_band_decode.sv
module mfv_band_decode
    import mfv_pkg::*;
#(
    parameter int LOW_LO    = 6,
    parameter int LOW_HI    = 9,
    parameter int MID_LO    = 24,
    parameter int MID_HI    = 27,
    parameter int TOP_LO    = 29,
    parameter int TOP_HI    = 32,
    parameter int MIX_SHIFT = 18
) (
    input  bcd5_t  setting,
    output remap_t rm
);

    localparam logic [COARSE_W-1:0] TEN = COARSE_W'(10);

    logic [DIGIT_W-1:0]    digs [NUM_DIGITS];
    logic [NUM_DIGITS-1:0] digit_ok;
    logic [COARSE_W-1:0]   coarse;
    logic [COARSE_W-1:0]   shifted;
    logic                  in_low;
    logic                  in_up;

    assign digs[0] = setting.hundredth;
    assign digs[1] = setting.tenth;
    assign digs[2] = setting.units;
    assign digs[3] = setting.tens;
    assign digs[4] = setting.hund;

    // Every digit must be a legal decimal digit
    for (genvar gi = 0; gi < NUM_DIGITS; gi++) begin : g_digit_chk
        assign digit_ok[gi] = (digs[gi] <= DIGIT_W'(9));
    end

    assign coarse = COARSE_W'(setting.hund) * TEN + COARSE_W'(setting.tens);

    assign in_low = (coarse >= COARSE_W'(LOW_LO)) && (coarse <= COARSE_W'(LOW_HI));
    assign in_up  = ((coarse >= COARSE_W'(MID_LO)) && (coarse <= COARSE_W'(MID_HI))) ||
                    ((coarse >= COARSE_W'(TOP_LO)) && (coarse <= COARSE_W'(TOP_HI)));

    assign shifted = in_up ? (coarse - COARSE_W'(MIX_SHIFT)) : coarse;

    always_comb begin
        rm = '0;
        if ((&digit_ok) && (in_low || in_up)) begin
            rm.ok    = 1'b1;
            rm.mixed = in_up;
            rm.hund  = DIGIT_W'(shifted / TEN);
            rm.tens  = DIGIT_W'(shifted % TEN);
        end
    end

endmodule

// File: rtl/mfv_blink_div.sv
module mfv_blink_div #(
    parameter int HALF_CYCLES = 50_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic blink
);

    localparam int CNT_W = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            blink <= 1'b0;
        end else if (cnt == LAST) begin
            cnt   <= '0;
            blink <= ~blink;
        end else begin
            cnt   <= cnt + 1'b1;
        end
    end

    AST_BLINK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != LAST) |=> $stable(blink)); // R9
    AST_BLINK_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == LAST) |=> (blink != $past(blink))); // R10

endmodule

// File: rtl/mfv_path_fsm.sv
module mfv_path_fsm
    import mfv_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  remap_t             rm,
    input  bcd5_t              setting,
    input  logic               marker_en,
    input  logic               blink,
    output logic [DIGIT_W-1:0] syn_hund,
    output logic [DIGIT_W-1:0] syn_tens,
    output logic [DIGIT_W-1:0] syn_units,
    output logic [DIGIT_W-1:0] syn_tenth,
    output logic [DIGIT_W-1:0] syn_hundredth,
    output logic               path_direct,
    output logic               path_mixed,
    output logic               fault_lamp,
    output logic               marker_lamp
);

    mfv_state_e state_q;
    mfv_state_e state_d;
    mfv_state_e target;

    // Target chosen from the decoded setting; fault has priority
    always_comb begin
        if (!rm.ok)          target = ST_FAULT;
        else if (!marker_en) target = ST_PARKED;
        else if (rm.mixed)   target = ST_MIXED;
        else                 target = ST_DIRECT;
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE:   state_d = target;
            ST_PARKED: state_d = target;
            ST_DIRECT: state_d = target;
            ST_MIXED:  state_d = target;
            ST_FAULT:  state_d = target;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Synthesizer digit word, registered alongside the state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            syn_hund      <= '0;
            syn_tens      <= '0;
            syn_units     <= '0;
            syn_tenth     <= '0;
            syn_hundredth <= '0;
        end else begin
            syn_hund      <= rm.ok ? rm.hund : '0;
            syn_tens      <= rm.ok ? rm.tens : '0;
            syn_units     <= setting.units;
            syn_tenth     <= setting.tenth;
            syn_hundredth <= setting.hundredth;
        end
    end

    always_comb begin
        path_direct = 1'b0;
        path_mixed  = 1'b0;
        fault_lamp  = 1'b0;
        marker_lamp = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_PARKED: ;
            ST_DIRECT: begin
                path_direct = 1'b1;
                marker_lamp = blink;
            end
            ST_MIXED: begin
                path_mixed  = 1'b1;
                marker_lamp = blink;
            end
            ST_FAULT:  fault_lamp = blink;
            default:   ;
        endcase
    end

    AST_OFF_NO_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        !marker_en |=> !(path_direct || path_mixed)); // R7
    AST_BAD_ZERO_SYN: assert property (@(posedge clk) disable iff (!rst_n)
        !rm.ok |=> (syn_hund == '0 && syn_tens == '0 && !path_direct && !path_mixed)); // R5
    AST_LOW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (syn_units == $past(setting.units) && syn_tenth == $past(setting.tenth))); // R6

endmodule

// File: rtl/mfv_marker_validator.sv
module mfv_marker_validator
    import mfv_pkg::*;
#(
    parameter int HALF_CYCLES = 50_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] tw_hund,
    input  logic [3:0] tw_tens,
    input  logic [3:0] tw_units,
    input  logic [3:0] tw_tenth,
    input  logic [3:0] tw_hundredth,
    input  logic       marker_en,
    output logic [3:0] syn_hund,
    output logic [3:0] syn_tens,
    output logic [3:0] syn_units,
    output logic [3:0] syn_tenth,
    output logic [3:0] syn_hundredth,
    output logic       path_direct,
    output logic       path_mixed,
    output logic       fault_lamp,
    output logic       marker_lamp
);

    bcd5_t  setting;
    remap_t rm;
    logic   blink;

    assign setting = '{hund: tw_hund, tens: tw_tens, units: tw_units,
                       tenth: tw_tenth, hundredth: tw_hundredth};

    mfv_band_decode u_decode (
        .setting (setting),
        .rm      (rm)
    );

    mfv_blink_div #(.HALF_CYCLES(HALF_CYCLES)) u_blink (
        .clk   (clk),
        .rst_n (rst_n),
        .blink (blink)
    );

    mfv_path_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .rm            (rm),
        .setting       (setting),
        .marker_en     (marker_en),
        .blink         (blink),
        .syn_hund      (syn_hund),
        .syn_tens      (syn_tens),
        .syn_units     (syn_units),
        .syn_tenth     (syn_tenth),
        .syn_hundredth (syn_hundredth),
        .path_direct   (path_direct),
        .path_mixed    (path_mixed),
        .fault_lamp    (fault_lamp),
        .marker_lamp   (marker_lamp)
    );

    AST_DIRECT_DIGITS: assert property (@(posedge clk) disable iff (!rst_n)
        path_direct |-> (syn_hund == 4'd0 && syn_tens >= 4'd6 && syn_tens <= 4'd9)); // R2
    AST_MIXED_DIGITS: assert property (@(posedge clk) disable iff (!rst_n)
        path_mixed |-> ((syn_hund == 4'd0 && syn_tens >= 4'd6 && syn_tens <= 4'd9) ||
                        (syn_hund == 4'd1 && syn_tens >= 4'd1 && syn_tens <= 4'd4))); // R3
    AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        fault_lamp |-> (!path_direct && !path_mixed && !marker_lamp)); // R5

endmodule

// File: tb/mfv_marker_validator_tb.sv
module mfv_marker_validator_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] tw_hund = '0, tw_tens = '0, tw_units = '0, tw_tenth = '0, tw_hundredth = '0;
    logic       marker_en = 1'b0;
    logic [3:0] syn_hund, syn_tens, syn_units, syn_tenth, syn_hundredth;
    logic       path_direct, path_mixed, fault_lamp, marker_lamp;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    mfv_marker_validator #(.HALF_CYCLES(HALF)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .tw_hund(tw_hund), .tw_tens(tw_tens), .tw_units(tw_units),
        .tw_tenth(tw_tenth), .tw_hundredth(tw_hundredth), .marker_en(marker_en),
        .syn_hund(syn_hund), .syn_tens(syn_tens), .syn_units(syn_units),
        .syn_tenth(syn_tenth), .syn_hundredth(syn_hundredth),
        .path_direct(path_direct), .path_mixed(path_mixed),
        .fault_lamp(fault_lamp), .marker_lamp(marker_lamp)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference model from the requirements
    task automatic model(input int h, input int t, input int u, input int d1, input int d2,
                         output bit ok, output bit mix, output int eh, output int et);
        int f;
        bit bcd;
        f   = h * 10 + t;
        bcd = (h <= 9) && (t <= 9) && (u <= 9) && (d1 <= 9) && (d2 <= 9);
        ok  = 1'b0; mix = 1'b0; eh = 0; et = 0;
        if (bcd && f >= 6 && f <= 9) begin
            ok = 1'b1; eh = f / 10; et = f % 10;
        end else if (bcd && ((f >= 24 && f <= 27) || (f >= 29 && f <= 32))) begin
            ok = 1'b1; mix = 1'b1; eh = (f - 18) / 10; et = (f - 18) % 10;
        end
    endtask

    task automatic apply(input int h, input int t, input int u, input int d1, input int d2,
                         input bit en);
        bit ok, mix;
        int eh, et;
        @(negedge clk);
        tw_hund = 4'(h); tw_tens = 4'(t); tw_units = 4'(u);
        tw_tenth = 4'(d1); tw_hundredth = 4'(d2); marker_en = en;
        @(negedge clk);
        model(h, t, u, d1, d2, ok, mix, eh, et);
        if (!ok) begin
            check("R5 syn_hund invalid", int'(syn_hund), 0);
            check("R5 syn_tens invalid", int'(syn_tens), 0);
            check("R1 no path when invalid", int'(path_direct | path_mixed), 0);
        end else if (mix) begin
            check("R3 syn_hund remap", int'(syn_hund), eh);
            check("R3 syn_tens remap", int'(syn_tens), et);
            check("R4 path_mixed", int'(path_mixed), int'(en));
            check("R4 path_direct off", int'(path_direct), 0);
        end else begin
            check("R2 syn_hund low", int'(syn_hund), eh);
            check("R2 syn_tens low", int'(syn_tens), et);
            check("R2 path_direct", int'(path_direct), int'(en));
            check("R2 path_mixed off", int'(path_mixed), 0);
        end
        if (!en) check("R7 paths off when disabled", int'(path_direct | path_mixed), 0);
        check("R6 units", int'(syn_units), u);
        check("R6 tenth", int'(syn_tenth), d1);
        check("R6 hundredth", int'(syn_hundredth), d2);
    endtask

    task automatic lamp_window(input int exp_fault, input int exp_marker);
        int nf = 0;
        int nm = 0;
        for (int k = 0; k < 2 * HALF; k++) begin
            @(negedge clk);
            nf += int'(fault_lamp);
            nm += int'(marker_lamp);
        end
        check("R9 fault lamp lit clocks", nf, exp_fault);
        check("R10 marker lamp lit clocks", nm, exp_marker);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h0005_eed1));
        tw_hund = 4'd2; tw_tens = 4'd5; marker_en = 1'b1;
        repeat (3) @(negedge clk);
        // R8 reset state
        check("R8 reset syn_tens", int'(syn_tens), 0);
        check("R8 reset paths", int'(path_direct | path_mixed), 0);
        check("R8 reset lamps", int'(fault_lamp | marker_lamp), 0);
        rst_n = 1'b1;

        // Band edges
        apply(0, 6, 0, 0, 0, 1);
        apply(0, 5, 9, 9, 9, 1);
        apply(0, 9, 9, 9, 9, 1);
        apply(1, 0, 0, 0, 0, 1);
        apply(2, 3, 9, 9, 9, 1);
        apply(2, 4, 0, 0, 0, 1);
        apply(2, 7, 9, 9, 9, 1);
        apply(2, 8, 0, 0, 0, 1);
        apply(2, 8, 9, 9, 9, 1);
        apply(2, 9, 0, 0, 0, 1);
        apply(3, 2, 9, 9, 9, 1);
        apply(3, 3, 0, 0, 0, 1);
        // Non-decimal digits
        apply(0, 10, 0, 0, 0, 1);
        apply(0, 7, 0, 12, 0, 1);
        apply(15, 2, 0, 0, 0, 1);
        // Marker off with valid settings
        apply(2, 5, 3, 4, 5, 0);
        apply(0, 8, 1, 2, 3, 0);

        // R8: output holds until the next rising edge
        apply(0, 7, 0, 0, 0, 1);
        @(negedge clk);
        tw_hund = 4'd3; tw_tens = 4'd1;
        #1;
        check("R8 before edge syn_tens", int'(syn_tens), 7);
        @(negedge clk);
        check("R8 after edge syn_tens", int'(syn_tens), 3);

        // Lamp duty windows
        apply(1, 5, 0, 0, 0, 1);
        lamp_window(HALF, 0);
        apply(2, 6, 0, 0, 0, 1);
        lamp_window(0, HALF);
        apply(0, 6, 0, 0, 0, 1);
        lamp_window(0, HALF);
        apply(3, 0, 0, 0, 0, 0);
        lamp_window(0, 0);

        // Random mix
        for (int n = 0; n < 300; n++) begin
            int h, t, u, d1, d2;
            bit en;
            case ($urandom_range(0, 3))
                0:       h = 0;
                1:       h = 2;
                2:       h = 3;
                default: h = int'($urandom_range(0, 15));
            endcase
            t  = ($urandom_range(0, 9) == 0) ? int'($urandom_range(10, 15)) : int'($urandom_range(0, 9));
            u  = int'($urandom_range(0, 9));
            d1 = ($urandom_range(0, 19) == 0) ? 11 : int'($urandom_range(0, 9));
            d2 = int'($urandom_range(0, 9));
            en = ($urandom_range(0, 3) != 0);
            apply(h, t, u, d1, d2, en);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule